// File: doc/BRIEF.md
# Pointer-Addressed Sensor Register Target on I2C

This block is the bus-facing side of a digital temperature sensor. It sits on SCL and SDA lines that have already been synchronised and oversampled by the system clock. It pulls SDA low through a registered open-drain enable. After a START it shifts in an address byte and compares it with a 7-bit address that it latched from pins. In a write transfer it first loads a pointer byte, then stores later bytes into one of four 16-bit registers. In a read transfer it returns the register that the last pointer write selected.

The four registers hold the conversion result, the configuration and two 12-bit alarm thresholds. The block also serves general-call commands that relatch the address pins or restore the power-up state. It answers the alert response address with its own address and a cause bit, and it gives up that reply if it loses arbitration. A per-line stuck-bus timer returns the interface to idle. A strobe on each read data byte lets neighbouring alarm logic clear an interrupt-style alert.

Top module: `tsense_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal the latched address is acknowledged by holding SDA low for the ninth clock. Any other address byte gets no acknowledge, and this includes a master code of the form 00001xxx. The latched address is taken from `addr_pins_i` at reset.
- R2: In a write transfer, the first byte after the address is loaded as the pointer. Pointer bits 1:0 select the register: 00 is temperature, 01 is configuration, 10 is the low threshold and 11 is the high threshold. The pointer resets to 00.
- R3: A read returns the selected 16-bit word, upper byte first and then the lower byte, and then wraps to the upper byte again. Reads keep using the last pointer that was written. A NACK from the master ends the read.
- R4: Each threshold is 12 bits wide and sits in word bits 15:4, so word bits 3:0 read as zero. The upper byte is staged and the value changes only when the lower byte arrives. The low threshold resets to 0x4B0 and the high threshold resets to 0x500.
- R5: Configuration bits 6:0 are stored, reset to zero and appear on `cfg_o`. The configuration word reads as {0, bits 6:0, 8'h00}. Writing a one to bit 7 gives a one-cycle `oneshot_o` pulse, and bit 7 always reads as zero.
- R6: The temperature register resets to zero and loads `temp_i` when `temp_we_i` is high. Bus writes to it are acknowledged but ignored.
- R7: The general-call byte 0x00 is acknowledged. A command byte 0x04 relatches the address pins only. A command byte 0x06 relatches the address pins and returns every register and the pointer to its reset value.
- R8: The alert response byte 0x19 is acknowledged only while `alert_act_i` is high. The reply byte is {address, cause}, where cause is 1 when the signed temperature is greater than or equal to the signed high threshold.
- R9: If SDA is low while the block sends a 1 in the alert reply, the block releases the bus and does not pulse `ara_won_o`. After a full reply with no loss, `ara_won_o` pulses for one cycle.
- R10: After a START, if SCL or SDA stays low for TIMEOUT_CYC consecutive cycles, the block releases SDA and ignores the bus until the next START.
- R11: `rd_pulse_o` pulses for one cycle at the acknowledge bit of every register read data byte. It does not pulse for the alert reply.
- R12: A START at any point restarts the address phase, and a STOP releases SDA and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_pins_i | input | 7 | Address strap inputs |
| temp_i | input | 12 | New conversion result |
| temp_we_i | input | 1 | Load strobe for temp_i |
| alert_act_i | input | 1 | Alert currently asserted |
| cfg_o | output | 7 | Stored configuration bits 6:0 |
| tlow_o | output | 12 | Low threshold |
| thigh_o | output | 12 | High threshold |
| oneshot_o | output | 1 | Single-conversion request pulse |
| rd_pulse_o | output | 1 | Read data byte strobe |
| ara_won_o | output | 1 | Alert reply completed without loss |

## Verification
The bench targets threshold writes that are cut short after the upper byte. A design that stored the staged byte early would show a half-updated threshold on `thigh_o`. It also reads three bytes in a row, which catches a design that fails to wrap back to the upper byte. Further cases cover a pointer that is reused over several reads, general-call relatch and reset with changed strap pins, and master codes. The alert reply is run both with and without a forced low bit: a block that ignores lost arbitration would pulse `ara_won_o` or corrupt the byte that is received. A master that stalls in the acknowledge bit checks that the stuck timer lets go of SDA. A block with no such timer would hold the bus low for ever.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int ADDR_W = 7;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_PTR, PH_DATA, PH_GC} phase_t;

  localparam logic [7:0] GC_WR_BYTE  = 8'h00;
  localparam logic [7:0] ARA_RD_BYTE = 8'h19;
  localparam logic [7:0] GC_RELATCH  = 8'h04;
  localparam logic [7:0] GC_RESET    = 8'h06;

  localparam logic [1:0] SEL_TEMP  = 2'b00;
  localparam logic [1:0] SEL_CFG   = 2'b01;
  localparam logic [1:0] SEL_TLOW  = 2'b10;
  localparam logic [1:0] SEL_THIGH = 2'b11;
endpackage

// File: rtl/tsi_bus_cond.sv
module tsi_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
endmodule

// File: rtl/tsi_stuck_timer.sv
module tsi_stuck_timer #(
  parameter int TIMEOUT_CYC = 2_700_000,
  parameter int N_LINES     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic               tmo_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic               active;
  logic [N_LINES-1:0] hit;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [CW-1:0] low_cnt;
    always_ff @(posedge clk) begin
      if (rst || !active || lines_i[g]) low_cnt <= '0;
      else if (low_cnt != LIMIT)        low_cnt <= low_cnt + 1'b1;
    end
    assign hit[g] = active && !lines_i[g] && (low_cnt == LIMIT);
  end

  assign tmo_o = |hit;

  always_ff @(posedge clk) begin
    if (rst)                  active <= 1'b0;
    else if (start_i)         active <= 1'b1;
    else if (stop_i || tmo_o) active <= 1'b0;
  end
endmodule

// File: rtl/tsi_reg_bank.sv
module tsi_reg_bank
  import tsi_pkg::*;
#(
  parameter int                DATA_W    = 12,
  parameter logic [DATA_W-1:0] TLOW_RST  = 12'h4B0,
  parameter logic [DATA_W-1:0] THIGH_RST = 12'h500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic              wr_lsb_i,
  input  logic [7:0]        wr_data_i,
  input  logic              temp_we_i,
  input  logic [DATA_W-1:0] temp_i,
  input  logic [1:0]        rd_sel_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [6:0]        cfg_o,
  output logic [DATA_W-1:0] tlow_o,
  output logic [DATA_W-1:0] thigh_o,
  output logic              oneshot_o,
  output logic              cause_o
);
  localparam int PAD_W = WORD_W - DATA_W;
  localparam int LO_W  = DATA_W - 8;

  logic [DATA_W-1:0] temp_q, tlow_q, thigh_q;
  logic [6:0]        cfg_q;
  logic [7:0]        stage_q;

  always_ff @(posedge clk) begin
    oneshot_o <= 1'b0;
    if (rst || soft_rst_i) begin
      temp_q  <= '0;
      tlow_q  <= TLOW_RST;
      thigh_q <= THIGH_RST;
      cfg_q   <= '0;
      stage_q <= '0;
    end else begin
      if (temp_we_i) temp_q <= temp_i;
      if (wr_en_i) begin
        if (!wr_lsb_i) stage_q <= wr_data_i;
        case (wr_sel_i)
          SEL_CFG: if (!wr_lsb_i) begin
            cfg_q     <= wr_data_i[6:0];
            oneshot_o <= wr_data_i[7];
          end
          SEL_TLOW:  if (wr_lsb_i) tlow_q  <= {stage_q, wr_data_i[7 -: LO_W]};
          SEL_THIGH: if (wr_lsb_i) thigh_q <= {stage_q, wr_data_i[7 -: LO_W]};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel_i)
      SEL_TEMP: rd_word_o = {temp_q, {PAD_W{1'b0}}};
      SEL_CFG:  rd_word_o = {1'b0, cfg_q, 8'h00};
      SEL_TLOW: rd_word_o = {tlow_q, {PAD_W{1'b0}}};
      default:  rd_word_o = {thigh_q, {PAD_W{1'b0}}};
    endcase
  end

  assign cfg_o   = cfg_q;
  assign tlow_o  = tlow_q;
  assign thigh_o = thigh_q;
  assign cause_o = $signed(temp_q) >= $signed(thigh_q);

  a_r7_soft_reset_values: assert property (@(posedge clk) disable iff (rst)
    soft_rst_i |=> (cfg_q == '0 && tlow_q == TLOW_RST && thigh_q == THIGH_RST && temp_q == '0));
  a_r6_temp_readonly: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_sel_i == SEL_TEMP && !temp_we_i && !soft_rst_i) |=> $stable(temp_q));
  a_r5_oneshot_single: assert property (@(posedge clk) disable iff (rst)
    oneshot_o |=> !oneshot_o);
endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tmo_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] addr_pins_i,
  input  logic              alert_act_i,
  input  logic              cause_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [1:0]        rd_sel_o,
  output logic              wr_en_o,
  output logic [1:0]        wr_sel_o,
  output logic              wr_lsb_o,
  output logic [7:0]        wr_data_o,
  output logic              soft_rst_o,
  output logic              sda_oe_o,
  output logic              rd_pulse_o,
  output logic              ara_won_o
);
  state_t            state;
  phase_t            phase;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx_sh, tx_next;
  logic [1:0]        ptr;
  logic [ADDR_W-1:0] addr_q;
  logic              byte_idx, ara_mode, mack, next_tx;

  always_comb begin
    if (ara_mode)      tx_next = {addr_q, cause_i};
    else if (byte_idx) tx_next = rd_word_i[7:0];
    else               tx_next = rd_word_i[15:8];
  end

  always_ff @(posedge clk) begin
    wr_en_o    <= 1'b0;
    soft_rst_o <= 1'b0;
    rd_pulse_o <= 1'b0;
    ara_won_o  <= 1'b0;
    if (rst) begin
      state <= S_IDLE; phase <= PH_ADDR; cnt <= '0; sh <= '0; tx_sh <= '0;
      ptr <= '0; addr_q <= addr_pins_i; byte_idx <= 1'b0; ara_mode <= 1'b0;
      mack <= 1'b0; next_tx <= 1'b0; sda_oe_o <= 1'b0;
      wr_sel_o <= '0; wr_lsb_o <= 1'b0; wr_data_o <= '0;
    end else if (start_i) begin
      state <= S_RX; phase <= PH_ADDR; cnt <= '0;
      ara_mode <= 1'b0; byte_idx <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_i || tmo_i) begin
      state <= S_IDLE; sda_oe_o <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise_i && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (scl_fall_i && cnt == 4'd8) begin
            state    <= S_ACK;
            sda_oe_o <= 1'b1;
            next_tx  <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (sh[7:1] == addr_q) begin
                  next_tx  <= sh[0];
                  phase    <= PH_PTR;
                  byte_idx <= 1'b0;
                end else if (sh == GC_WR_BYTE) begin
                  phase <= PH_GC;
                end else if (sh == ARA_RD_BYTE && alert_act_i) begin
                  ara_mode <= 1'b1;
                  next_tx  <= 1'b1;
                end else begin
                  state    <= S_IDLE;
                  sda_oe_o <= 1'b0;
                end
              end
              PH_PTR: begin
                ptr      <= sh[1:0];
                phase    <= PH_DATA;
                byte_idx <= 1'b0;
              end
              PH_DATA: begin
                wr_en_o   <= 1'b1;
                wr_sel_o  <= ptr;
                wr_lsb_o  <= byte_idx;
                wr_data_o <= sh;
                byte_idx  <= ~byte_idx;
              end
              default: begin
                if (sh == GC_RELATCH || sh == GC_RESET) addr_q <= addr_pins_i;
                if (sh == GC_RESET) begin
                  soft_rst_o <= 1'b1;
                  ptr        <= '0;
                end
              end
            endcase
          end
        end
        S_ACK: if (scl_fall_i) begin
          cnt <= '0;
          if (next_tx) begin
            tx_sh    <= tx_next;
            sda_oe_o <= ~tx_next[7];
            state    <= S_TX;
          end else begin
            sda_oe_o <= 1'b0;
            state    <= S_RX;
          end
        end
        S_TX: begin
          if (scl_rise_i && ara_mode && tx_sh[7] && !sda_i) begin
            state    <= S_IDLE;
            sda_oe_o <= 1'b0;
          end else if (scl_fall_i) begin
            if (cnt == 4'd7) begin
              sda_oe_o  <= 1'b0;
              state     <= S_MACK;
              ara_won_o <= ara_mode;
            end else begin
              cnt      <= cnt + 1'b1;
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_oe_o <= ~tx_sh[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise_i) begin
            mack       <= ~sda_i;
            rd_pulse_o <= ~ara_mode;
            byte_idx   <= ~byte_idx;
          end else if (scl_fall_i) begin
            if (mack && !ara_mode) begin
              cnt      <= '0;
              tx_sh    <= tx_next;
              sda_oe_o <= ~tx_next[7];
              state    <= S_TX;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_sel_o = ptr;

  a_r10_timeout_release: assert property (@(posedge clk) disable iff (rst)
    tmo_i |=> !sda_oe_o);
  a_r12_start_release: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !sda_oe_o);
  a_r11_rd_pulse_single: assert property (@(posedge clk) disable iff (rst)
    rd_pulse_o |=> !rd_pulse_o);
  a_r9_won_not_read: assert property (@(posedge clk) disable iff (rst)
    ara_won_o |=> !rd_pulse_o);
endmodule

// File: rtl/tsense_i2c_target.sv
module tsense_i2c_target
  import tsi_pkg::*;
#(
  parameter int                DATA_W      = 12,
  parameter int                TIMEOUT_CYC = 2_700_000,
  parameter logic [DATA_W-1:0] TLOW_RST    = 12'h4B0,
  parameter logic [DATA_W-1:0] THIGH_RST   = 12'h500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [6:0]        addr_pins_i,
  input  logic [DATA_W-1:0] temp_i,
  input  logic              temp_we_i,
  input  logic              alert_act_i,
  output logic [6:0]        cfg_o,
  output logic [DATA_W-1:0] tlow_o,
  output logic [DATA_W-1:0] thigh_o,
  output logic              oneshot_o,
  output logic              rd_pulse_o,
  output logic              ara_won_o
);
  logic              scl_rise, scl_fall, start, stop, tmo;
  logic              wr_en, wr_lsb, soft_rst, cause;
  logic [1:0]        wr_sel, rd_sel;
  logic [7:0]        wr_data;
  logic [WORD_W-1:0] rd_word;

  tsi_bus_cond i_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  tsi_stuck_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .N_LINES(2)) i_timer (
    .clk(clk), .rst(rst), .lines_i({scl_i, sda_i}),
    .start_i(start), .stop_i(stop), .tmo_o(tmo)
  );

  tsi_core i_core (
    .clk(clk), .rst(rst), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .tmo_i(tmo), .sda_i(sda_i),
    .addr_pins_i(addr_pins_i), .alert_act_i(alert_act_i), .cause_i(cause),
    .rd_word_i(rd_word), .rd_sel_o(rd_sel), .wr_en_o(wr_en), .wr_sel_o(wr_sel),
    .wr_lsb_o(wr_lsb), .wr_data_o(wr_data), .soft_rst_o(soft_rst),
    .sda_oe_o(sda_oe_o), .rd_pulse_o(rd_pulse_o), .ara_won_o(ara_won_o)
  );

  tsi_reg_bank #(.DATA_W(DATA_W), .TLOW_RST(TLOW_RST), .THIGH_RST(THIGH_RST)) i_bank (
    .clk(clk), .rst(rst), .soft_rst_i(soft_rst), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_lsb_i(wr_lsb), .wr_data_i(wr_data),
    .temp_we_i(temp_we_i), .temp_i(temp_i), .rd_sel_i(rd_sel),
    .rd_word_o(rd_word), .cfg_o(cfg_o), .tlow_o(tlow_o), .thigh_o(thigh_o),
    .oneshot_o(oneshot_o), .cause_o(cause)
  );
endmodule

// File: tb/test_tsense_i2c_target.sv
`timescale 1ns/1ps
module test_tsense_i2c_target;
  localparam int H   = 8;
  localparam int TMO = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [6:0]  addr_pins = 7'h48;
  logic [11:0] temp_in = '0;
  logic        temp_we = 1'b0;
  logic        alert_act = 1'b0;
  logic        sda_oe, oneshot, rd_pulse, ara_won;
  logic [6:0]  cfg;
  logic [11:0] tlow, thigh;
  wire         sda_line = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0;
  int n_os = 0, n_rd = 0, n_won = 0;

  logic [6:0]  m_cfg;
  logic [11:0] m_tlow, m_thigh, m_temp;

  always #2 clk = ~clk;

  tsense_i2c_target #(.TIMEOUT_CYC(TMO)) i_tsense_i2c_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_pins_i(addr_pins), .temp_i(temp_in), .temp_we_i(temp_we),
    .alert_act_i(alert_act), .cfg_o(cfg), .tlow_o(tlow), .thigh_o(thigh),
    .oneshot_o(oneshot), .rd_pulse_o(rd_pulse), .ara_won_o(ara_won)
  );

  always @(posedge clk) begin
    if (oneshot)  n_os++;
    if (rd_pulse) n_rd++;
    if (ara_won)  n_won++;
  end

  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0; hw(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(H);
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H/2); ack = ~sda_line; hw(H/2); scl_m = 1'b0;
  endtask

  task automatic rb(input logic nack, input logic [7:0] f0, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = ~f0[i]; hw(H); scl_m = 1'b1; hw(H/2); d[i] = sda_line; hw(H/2); scl_m = 1'b0;
    end
    sda_m = nack; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input int nb,
                        input logic [15:0] w, output logic ack);
    logic k;
    bus_start(); wb({a, 1'b0}, ack); wb(p, k);
    if (nb >= 1) wb(w[15:8], k);
    if (nb >= 2) wb(w[7:0], k);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [15:0] w, output logic ack);
    logic [7:0] hi, lo;
    bus_start(); wb({a, 1'b1}, ack);
    if (ack) begin rb(1'b0, 8'h00, hi); rb(1'b1, 8'h00, lo); w = {hi, lo}; end
    else w = 16'hFFFF;
    bus_stop();
  endtask

  task automatic load_temp(input logic [11:0] t);
    temp_in = t; temp_we = 1'b1; hw(1); temp_we = 1'b0; m_temp = t;
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] sel);
    case (sel)
      2'd0:    return {m_temp, 4'h0};
      2'd1:    return {1'b0, m_cfg, 8'h00};
      2'd2:    return {m_tlow, 4'h0};
      default: return {m_thigh, 4'h0};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic ack, k;
    logic [15:0] w;
    logic [7:0]  d0, d1, d2;
    int os0, rd0, won0;
    void'($urandom(32'd20240611));
    m_cfg = '0; m_tlow = 12'h4B0; m_thigh = 12'h500; m_temp = '0;
    hw(5); rst = 1'b0; hw(2);

    chk("R12 reset sda released", sda_oe, 0);
    chk("R4 reset thigh", thigh, 12'h500);
    chk("R4 reset tlow", tlow, 12'h4B0);
    chk("R5 reset cfg", cfg, 0);
    rd0 = n_rd;
    rd_reg(7'h48, w, ack);
    chk("R1 own address acked", ack, 1);
    chk("R2 R6 default pointer reads zero temp", w, 16'h0000);
    chk("R11 two read pulses", n_rd - rd0, 2);

    rd_reg(7'h49, w, ack);
    chk("R1 other address not acked", ack, 0);
    bus_start(); wb(8'h0B, ack); bus_stop();
    chk("R1 master code not acked", ack, 0);

    load_temp(12'h190);
    rd_reg(7'h48, w, ack);
    chk("R6 temp load read", w, exp_word(2'd0));

    for (int it = 0; it < 24; it++) begin
      logic [1:0]  sel;
      logic [15:0] v;
      sel = 2'(1 + ($urandom % 3));
      v = 16'($urandom);
      os0 = n_os;
      wr_reg(7'h48, {6'($urandom), sel}, 2, v, ack);
      if (sel == 2'd1) m_cfg = v[14:8];
      else if (sel == 2'd2) m_tlow = v[15:4];
      else m_thigh = v[15:4];
      rd_reg(7'h48, w, ack);
      chk($sformatf("R2 R3 R4 R5 random sel %0d", sel), w, exp_word(sel));
      if (sel == 2'd1) chk("R5 oneshot pulse count", n_os - os0, 32'(v[15]));
      if (it % 6 == 0) begin
        load_temp(12'($urandom));
        wr_reg(7'h48, 8'h00, 2, 16'($urandom), ack);
        rd_reg(7'h48, w, ack);
        chk("R6 temp write ignored", w, exp_word(2'd0));
      end
    end
    chk("R5 cfg port", cfg, m_cfg);
    chk("R4 thigh port", thigh, m_thigh);

    wr_reg(7'h48, 8'h03, 0, 16'h0, ack);
    rd_reg(7'h48, w, ack);
    chk("R3 pointer reuse first", w, exp_word(2'd3));
    rd_reg(7'h48, w, ack);
    chk("R3 pointer reuse second", w, exp_word(2'd3));

    bus_start(); wb(8'h91, ack);
    rb(1'b0, 8'h00, d0); rb(1'b0, 8'h00, d1); rb(1'b1, 8'h00, d2); bus_stop();
    chk("R3 wrap to upper byte", {d0, d1, d2}, {exp_word(2'd3), exp_word(2'd3)[15:8]});

    bus_start(); wb(8'h90, ack); wb(8'h03, k); wb(8'h12, k);
    bus_start(); wb(8'h91, ack);
    rb(1'b0, 8'h00, d0); rb(1'b1, 8'h00, d1); bus_stop();
    chk("R12 repeated start read acked", ack, 1);
    chk("R4 upper byte alone no change", {d0, d1}, exp_word(2'd3));

    addr_pins = 7'h4A;
    bus_start(); wb(8'h00, ack); wb(8'h04, k); bus_stop();
    chk("R7 general call acked", ack, 1);
    rd_reg(7'h48, w, ack);
    chk("R7 old address dropped", ack, 0);
    rd_reg(7'h4A, w, ack);
    chk("R7 new address acked", ack, 1);
    chk("R7 relatch keeps regs", w, exp_word(2'd3));

    addr_pins = 7'h4B;
    bus_start(); wb(8'h00, ack); wb(8'h06, k); bus_stop();
    m_cfg = '0; m_tlow = 12'h4B0; m_thigh = 12'h500; m_temp = '0;
    chk("R7 reset thigh", thigh, 12'h500);
    chk("R7 reset tlow", tlow, 12'h4B0);
    rd_reg(7'h4B, w, ack);
    chk("R7 reset relatch and pointer", {15'd0, ack, w}, {15'd0, 1'b1, 16'h0000});

    bus_start(); wb(8'h19, ack); bus_stop();
    chk("R8 alert reply refused when idle", ack, 0);
    alert_act = 1'b1;
    load_temp(12'h600);
    won0 = n_won; rd0 = n_rd;
    bus_start(); wb(8'h19, ack); rb(1'b1, 8'h00, d0); bus_stop();
    chk("R8 alert reply acked", ack, 1);
    chk("R8 reply high cause", d0, {7'h4B, 1'b1});
    chk("R9 won pulse", n_won - won0, 1);
    chk("R11 no read pulse on alert reply", n_rd - rd0, 0);
    load_temp(12'hC90);
    bus_start(); wb(8'h19, ack); rb(1'b1, 8'h00, d0); bus_stop();
    chk("R8 reply low cause", d0, {7'h4B, 1'b0});
    won0 = n_won;
    bus_start(); wb(8'h19, ack); rb(1'b1, 8'h80, d0); bus_stop();
    chk("R9 lost arbitration releases", d0, 8'h7F);
    chk("R9 no won pulse after loss", n_won - won0, 0);
    alert_act = 1'b0;

    bus_start();
    for (int i = 7; i >= 0; i--) begin
      sda_m = d1[0] ^ d1[0] ^ (8'h96 >> i) & 1'b1; hw(H); scl_m = 1'b1; hw(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(H);
    chk("R10 ack held before stall", sda_oe, 1);
    hw(TMO + 20);
    chk("R10 stuck bus released", sda_oe, 0);
    bus_stop();
    rd_reg(7'h4B, w, ack);
    chk("R10 recovers at next start", {15'd0, ack, w}, {15'd0, 1'b1, exp_word(2'd0)});

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule